// File: doc/BRIEF.md
# Scoped Reset Sequencer for a Management Register File

This block decides when, and how widely, a small management register file is returned to its defaults. The register file has three groups: the standard group, the extended group and the diagnostic/RAM group. The block drives one clear strobe per group. It also holds a latched copy of the board strap configuration, and it raises a busy flag that tells the management interface to hold off accesses while a reset runs.

Reset requests come from two sources. The first is an active-low hardware reset pin. It is synchronised and qualified by a cycle counter, so short glitches have no effect. The second is the register write port, where three self-clearing control bits each start a software reset of a different scope. A hardware reset clears every group and samples the straps again. A software reset clears only its own groups and leaves the latched configuration as it is.

Every duration is a parameter in clock cycles. The defaults assume a 25 MHz clock: a 25-cycle minimum pin pulse, a 33-cycle software reset, and a 75-cycle access hold-off.

Top module: `mgmt_reset_seq`

## Requirements
- R1: A low level on `hw_rst_n` that the synchroniser sees for fewer than `PIN_MIN_CYC` cycles is ignored: no clear strobe, no busy, and `cfg_o` is unchanged.
- R2: A low level seen for at least `PIN_MIN_CYC` cycles is a hardware reset. `busy_o` rises while the pin is still low. On release, `grp_clr_o` pulses 3'b111 for one cycle, `cfg_o` is loaded from `strap_i`, and `busy_o` stays high for `HOLD_CYC` cycles counted from that pulse.
- R3: A write to address 0x0000 with data bit 15 set pulses `grp_clr_o` = 3'b001 (standard group only) one cycle after the write.
- R4: A write to address 0x001F with data bit 15 set pulses `grp_clr_o` = 3'b011 (standard and extended groups) and leaves `cfg_o` unchanged.
- R5: A write to address 0x0D01 with data bit 14 set pulses `grp_clr_o` = 3'b100 (diagnostic/RAM group only).
- R6: After an accepted software reset write, `busy_o` is high for exactly `HOLD_CYC` cycles, starting with the cycle of the clear pulse.
- R7: `ctl_bits_o` reads back the self-clearing control bits: bit 0 for the standard scope, bit 1 for the global scope, bit 2 for the diagnostic scope. The bit is 1 for exactly `DONE_CYC` cycles from the clear pulse, then returns to 0. At most one bit is set at any time.
- R8: A write is ignored when it arrives while `busy_o` is high, when it targets any other address, or when its control bit is 0.
- R9: A hardware reset that qualifies while a software reset is running aborts it. `ctl_bits_o` goes to 0, `busy_o` stays high, and the full hardware sequence of R2 follows on release.
- R10: While `por_n` is low, `busy_o` is high and the strobes, control bits and `cfg_o` are 0. On the first cycle after release, all three groups are cleared, `cfg_o` takes `strap_i`, and busy lasts `HOLD_CYC` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| hw_rst_n | input | 1 | Hardware reset pin, active low, asynchronous to `clk` |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| strap_i | input | CFG_W | Hardware configuration straps |
| grp_clr_o | output | 3 | One-cycle clear strobes: bit 0 standard, bit 1 extended, bit 2 diagnostic/RAM |
| cfg_o | output | CFG_W | Latched strap configuration |
| ctl_bits_o | output | 3 | Read-back value of the three self-clearing reset control bits |
| busy_o | output | 1 | Management access hold-off |

## Verification
The assertions assume that `wr_addr` and `wr_data` are only meaningful when `wr_en` is high. They also assume that the clear scopes map to distinct addresses, so that one write can never match two scopes. The bench writes a single register per access and holds each write for exactly one cycle. It changes the straps only while no hardware reset is in flight, and it changes the pin only between clock edges, so the synchroniser sees whole-cycle levels. Random glitches are kept strictly shorter than the qualification length. Exactly-at-threshold and hardware-during-software cases are driven as directed tests.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

   localparam int unsigned GRP_N   = 3;
   localparam int unsigned SCOPE_N = 3;

   localparam int unsigned SC_STD  = 0;
   localparam int unsigned SC_GLB  = 1;
   localparam int unsigned SC_DIAG = 2;

   localparam logic [GRP_N-1:0] GRP_ALL = '1;

   // Groups cleared by each software scope.
   function automatic logic [GRP_N-1:0] scope_groups(input int unsigned sc);
      case (sc)
         SC_STD:  return 3'b001;
         SC_GLB:  return 3'b011;
         SC_DIAG: return 3'b100;
         default: return '0;
      endcase
   endfunction

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic por_n,
   input  logic din,
   output logic dout
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad
         $error("rstseq_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_st
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) chain[i] <= 1'b1;
            else if (i == 0) chain[i] <= din;
            else chain[i] <= chain[(i == 0) ? 0 : i-1];
         end
      end
   endgenerate

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/rstseq_glitch_filter.sv
module rstseq_glitch_filter #(
   parameter int unsigned MIN_CYC = 25
) (
   input  logic clk,
   input  logic por_n,
   input  logic pin_s,
   output logic qual,
   output logic fire
);
   localparam int unsigned CW = $clog2(MIN_CYC + 1);
   localparam logic [CW-1:0] TOP = CW'(MIN_CYC);

   logic [CW-1:0] low_cnt;

   generate
      if (MIN_CYC < 1) begin : g_bad
         $error("rstseq_glitch_filter: MIN_CYC must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)             low_cnt <= '0;
      else if (pin_s)         low_cnt <= '0;
      else if (low_cnt != TOP) low_cnt <= low_cnt + 1'b1;
   end

   assign qual = (low_cnt == TOP);
   assign fire = qual & pin_s;
endmodule

// File: rtl/rstseq_timer.sv
module rstseq_timer #(
   parameter int unsigned LEN = 33
) (
   input  logic clk,
   input  logic por_n,
   input  logic load,
   input  logic flush,
   output logic running
);
   localparam int unsigned CW = $clog2(LEN + 1);
   localparam logic [CW-1:0] START = CW'(LEN);

   logic [CW-1:0] cnt;

   generate
      if (LEN < 1) begin : g_bad
         $error("rstseq_timer: LEN must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)          cnt <= '0;
      else if (load)       cnt <= START;
      else if (flush)      cnt <= '0;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign running = (cnt != '0);
endmodule

// File: rtl/rstseq_decode.sv
module rstseq_decode #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 16,
   parameter logic [ADDR_W-1:0] MATCH_ADDR = '0,
   parameter int unsigned BIT_POS = 15
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              hit
);
   generate
      if (BIT_POS >= DATA_W) begin : g_bad
         $error("rstseq_decode: BIT_POS outside the data word");
      end
   endgenerate

   assign hit = wr_en && (wr_addr == MATCH_ADDR) && wr_data[BIT_POS];
endmodule

// File: rtl/mgmt_reset_seq.sv
module mgmt_reset_seq
   import rstseq_pkg::*;
#(
   parameter int unsigned ADDR_W      = 16,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned CFG_W       = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned PIN_MIN_CYC = 25,
   parameter int unsigned DONE_CYC    = 33,
   parameter int unsigned HOLD_CYC    = 75,
   parameter logic [ADDR_W-1:0] STD_ADDR  = 'h0000,
   parameter logic [ADDR_W-1:0] GLB_ADDR  = 'h001F,
   parameter logic [ADDR_W-1:0] DIAG_ADDR = 'h0D01,
   parameter int unsigned STD_BIT  = 15,
   parameter int unsigned GLB_BIT  = 15,
   parameter int unsigned DIAG_BIT = 14
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              hw_rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [CFG_W-1:0]  strap_i,
   output logic [2:0]        grp_clr_o,
   output logic [CFG_W-1:0]  cfg_o,
   output logic [2:0]        ctl_bits_o,
   output logic              busy_o
);
   localparam logic [ADDR_W-1:0] SC_ADDR [SCOPE_N] = '{STD_ADDR, GLB_ADDR, DIAG_ADDR};
   localparam int unsigned       SC_BIT  [SCOPE_N] = '{STD_BIT, GLB_BIT, DIAG_BIT};

   generate
      if (DONE_CYC > HOLD_CYC) begin : g_bad_len
         $error("mgmt_reset_seq: DONE_CYC must not exceed HOLD_CYC");
      end
      if (STD_ADDR == GLB_ADDR || STD_ADDR == DIAG_ADDR || GLB_ADDR == DIAG_ADDR) begin : g_bad_addr
         $error("mgmt_reset_seq: scope addresses must be distinct");
      end
      if (GRP_N != 3) begin : g_bad_grp
         $error("mgmt_reset_seq: port widths assume three groups");
      end
   endgenerate

   // Pin path: synchroniser then low-level qualification.
   logic pin_s, hw_qual, hw_fire;

   rstseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .por_n(por_n), .din(hw_rst_n), .dout(pin_s)
   );

   rstseq_glitch_filter #(.MIN_CYC(PIN_MIN_CYC)) u_filt (
      .clk(clk), .por_n(por_n), .pin_s(pin_s), .qual(hw_qual), .fire(hw_fire)
   );

   // Software scope decode, one matcher per scope.
   logic [SCOPE_N-1:0] hit;

   generate
      for (genvar s = 0; s < SCOPE_N; s++) begin : g_scope
         rstseq_decode #(
            .ADDR_W(ADDR_W), .DATA_W(DATA_W),
            .MATCH_ADDR(SC_ADDR[s]), .BIT_POS(SC_BIT[s])
         ) u_dec (
            .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .hit(hit[s])
         );
      end
   endgenerate

   // Sequencing state.
   logic               init_pend;
   logic               hold_run, done_run;
   logic [SCOPE_N-1:0] scope_q;
   logic [GRP_N-1:0]   clr_q;
   logic [CFG_W-1:0]   cfg_q;

   logic             hw_event, sw_accept;
   logic [GRP_N-1:0] sw_groups;

   assign busy_o    = init_pend | hw_qual | hold_run;
   assign hw_event  = init_pend | hw_fire;
   assign sw_accept = (|hit) & ~busy_o;

   always_comb begin
      sw_groups = '0;
      for (int unsigned s = 0; s < SCOPE_N; s++) begin
         if (hit[s]) sw_groups = sw_groups | scope_groups(s);
      end
   end

   rstseq_timer #(.LEN(HOLD_CYC)) u_hold (
      .clk(clk), .por_n(por_n),
      .load(hw_event | sw_accept),
      .flush(hw_qual),
      .running(hold_run)
   );

   rstseq_timer #(.LEN(DONE_CYC)) u_done (
      .clk(clk), .por_n(por_n),
      .load(sw_accept & ~hw_event),
      .flush(hw_event | hw_qual),
      .running(done_run)
   );

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         init_pend <= 1'b1;
         clr_q     <= '0;
         cfg_q     <= '0;
         scope_q   <= '0;
      end else begin
         init_pend <= 1'b0;
         if (hw_event) begin
            clr_q <= GRP_ALL;
            cfg_q <= strap_i;
         end else if (sw_accept) begin
            clr_q   <= sw_groups;
            scope_q <= hit;
         end else begin
            clr_q <= '0;
         end
      end
   end

   assign grp_clr_o  = clr_q;
   assign cfg_o      = cfg_q;
   assign ctl_bits_o = scope_q & {SCOPE_N{done_run}};
endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk #(
   parameter int unsigned CFG_W = 8
) (
   input logic             clk,
   input logic             por_n,
   input logic             wr_en,
   input logic             busy_o,
   input logic [2:0]       grp_clr_o,
   input logic [CFG_W-1:0] cfg_o,
   input logic [2:0]       ctl_bits_o
);
   // R6: any clear strobe falls inside the hold-off window
   a_r6_clear_inside_busy: assert property (@(posedge clk) disable iff (!por_n)
      (|grp_clr_o) |-> busy_o);

   // R7: control bits read 1 only while accesses are held off
   a_r7_bits_imply_busy: assert property (@(posedge clk) disable iff (!por_n)
      (|ctl_bits_o) |-> busy_o);

   // R7: never more than one scope pending
   a_r7_single_scope: assert property (@(posedge clk) disable iff (!por_n)
      $onehot0(ctl_bits_o));

   // R3: clear strobes last one cycle
   a_r3_strobe_one_cycle: assert property (@(posedge clk) disable iff (!por_n)
      (|grp_clr_o) |=> (grp_clr_o == 3'b000));

   // R4: global software scope leaves the configuration latch alone
   a_r4_global_keeps_cfg: assert property (@(posedge clk) disable iff (!por_n)
      (grp_clr_o == 3'b011) |-> (cfg_o == $past(cfg_o)));

   // R2: the configuration only moves together with a full clear
   a_r2_cfg_moves_with_full_clear: assert property (@(posedge clk) disable iff (!por_n)
      (cfg_o != $past(cfg_o)) |-> (grp_clr_o == 3'b111));

   // R8: a write during hold-off never starts a partial clear
   a_r8_busy_write_dropped: assert property (@(posedge clk) disable iff (!por_n)
      (wr_en && busy_o) |=> (grp_clr_o == 3'b000 || grp_clr_o == 3'b111));
endmodule

bind mgmt_reset_seq rstseq_chk #(.CFG_W(CFG_W)) u_chk (
   .clk(clk), .por_n(por_n), .wr_en(wr_en), .busy_o(busy_o),
   .grp_clr_o(grp_clr_o), .cfg_o(cfg_o), .ctl_bits_o(ctl_bits_o)
);

// File: tb/sim_mgmt_reset_seq.sv
`timescale 1ns/1ps
module sim_mgmt_reset_seq;
   localparam int AW = 16, DW = 16, CW = 8;
   localparam int LOWC = 25, DONEC = 33, HOLDC = 75;

   logic clk = 1'b0, por_n = 1'b0, pin = 1'b1, wr = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] data = '0;
   logic [CW-1:0] strap = 8'hA5;
   logic [2:0] clr, bits;
   logic [CW-1:0] cfg;
   logic busy;

   int n_chk = 0, n_bad = 0;

   always #2.5 clk = ~clk;

   mgmt_reset_seq #(.ADDR_W(AW), .DATA_W(DW), .CFG_W(CW),
      .PIN_MIN_CYC(LOWC), .DONE_CYC(DONEC), .HOLD_CYC(HOLDC)) u0 (
      .clk(clk), .por_n(por_n), .hw_rst_n(pin), .wr_en(wr), .wr_addr(addr),
      .wr_data(data), .strap_i(strap), .grp_clr_o(clr), .cfg_o(cfg),
      .ctl_bits_o(bits), .busy_o(busy)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [2:0] exp_mask(input logic [AW-1:0] a, input logic [DW-1:0] d);
      if (a == 16'h0000 && d[15]) return 3'b001;
      if (a == 16'h001F && d[15]) return 3'b011;
      if (a == 16'h0D01 && d[14]) return 3'b100;
      return 3'b000;
   endfunction

   function automatic logic [2:0] exp_bits(input logic [AW-1:0] a, input logic [DW-1:0] d);
      if (a == 16'h0000 && d[15]) return 3'b001;
      if (a == 16'h001F && d[15]) return 3'b010;
      if (a == 16'h0D01 && d[14]) return 3'b100;
      return 3'b000;
   endfunction

   task automatic wait_idle();
      while (busy) @(negedge clk);
   endtask

   // Count busy cycles and control-bit cycles from the current negedge.
   task automatic count_busy(output int nb, output int nbt);
      nb = 0; nbt = 0;
      while (busy && nb < 1000) begin
         nb++;
         if (bits != 3'b000) nbt++;
         @(negedge clk);
      end
   endtask

   task automatic sw_case(input logic [AW-1:0] a, input logic [DW-1:0] d);
      logic [2:0] m;
      logic [CW-1:0] cfg_old;
      int nb, nbt;
      wait_idle();
      cfg_old = cfg;
      m = exp_mask(a, d);
      @(negedge clk); wr = 1'b1; addr = a; data = d;
      @(negedge clk); wr = 1'b0;
      chk(clr == m, (m == 3'b011) ? "R4 clear mask" : (m == 3'b100) ? "R5 clear mask" :
          (m == 3'b001) ? "R3 clear mask" : "R8 ignored write mask", int'(clr), int'(m));
      if (m != 3'b000) begin
         chk(bits == exp_bits(a, d), "R7 control bit readback", int'(bits), int'(exp_bits(a, d)));
         chk(cfg == cfg_old, "R4 cfg kept by software reset", int'(cfg), int'(cfg_old));
         count_busy(nb, nbt);
         chk(nb == HOLDC, "R6 busy length", nb, HOLDC);
         chk(nbt == DONEC, "R7 control bit self-clear time", nbt, DONEC);
         chk(bits == 3'b000, "R7 bit reads 0 afterwards", int'(bits), 0);
      end else begin
         chk(busy == 1'b0, "R8 ignored write busy", int'(busy), 0);
         chk(bits == 3'b000, "R8 ignored write bits", int'(bits), 0);
      end
   endtask

   task automatic hw_case(input int w, input logic [CW-1:0] s);
      logic [CW-1:0] cfg_old;
      logic [2:0] seen;
      bit busy_seen;
      int nb, nbt;
      wait_idle();
      cfg_old = cfg;
      strap = s;
      busy_seen = 1'b0;
      seen = 3'b000;
      @(negedge clk); pin = 1'b0;
      for (int i = 0; i < w; i++) begin
         @(negedge clk);
         if (busy) busy_seen = 1'b1;
         if (clr != 3'b000) seen = clr;
      end
      if (w >= LOWC + 2)
         chk(busy == 1'b1, "R2 busy while pin held low", int'(busy), 1);
      pin = 1'b1;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         if (busy) busy_seen = 1'b1;
         if (clr != 3'b000) begin
            seen = clr;
            break;
         end
      end
      if (w >= LOWC) begin
         chk(seen == 3'b111, "R2 full clear", int'(seen), 7);
         chk(cfg == s, "R2 straps relatched", int'(cfg), int'(s));
         count_busy(nb, nbt);
         chk(nb == HOLDC, "R2 busy after release", nb, HOLDC);
      end else begin
         chk(seen == 3'b000, "R1 glitch no clear", int'(seen), 0);
         chk(busy_seen == 1'b0, "R1 glitch no busy", int'(busy_seen), 0);
         chk(cfg == cfg_old, "R1 glitch cfg kept", int'(cfg), int'(cfg_old));
      end
   endtask

   initial begin : watchdog
      #(5.0 * 150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      int nb, nbt;
      logic [2:0] seen;
      int unsigned seed_dummy;
      seed_dummy = $urandom(32'd20240611);

      // R10: reset state
      repeat (4) @(negedge clk);
      chk(clr == 3'b000, "R10 reset clear", int'(clr), 0);
      chk(bits == 3'b000, "R10 reset bits", int'(bits), 0);
      chk(cfg == '0, "R10 reset cfg", int'(cfg), 0);
      chk(busy == 1'b1, "R10 reset busy", int'(busy), 1);
      por_n = 1'b1;
      @(negedge clk);
      chk(clr == 3'b111, "R10 power-up clear", int'(clr), 7);
      chk(cfg == 8'hA5, "R10 power-up straps", int'(cfg), 8'hA5);
      count_busy(nb, nbt);
      chk(nb == HOLDC, "R10 power-up busy length", nb, HOLDC);

      // Directed software scopes
      strap = 8'h3C;
      sw_case(16'h0000, 16'h8000);
      sw_case(16'h001F, 16'h8000);
      chk(cfg == 8'hA5, "R4 straps not resampled", int'(cfg), 8'hA5);
      sw_case(16'h0D01, 16'h4000);
      sw_case(16'h0D01, 16'h8000);
      sw_case(16'h0000, 16'h7FFF);
      sw_case(16'h0002, 16'hFFFF);

      // R1 / R2 boundary on pin length
      hw_case(LOWC - 1, 8'h11);
      hw_case(LOWC, 8'h22);
      hw_case(LOWC + 12, 8'h33);

      // R8: write during hold-off
      wait_idle();
      @(negedge clk); wr = 1'b1; addr = 16'h0000; data = 16'h8000;
      @(negedge clk); addr = 16'h001F;
      chk(clr == 3'b001, "R3 first write accepted", int'(clr), 1);
      @(negedge clk); wr = 1'b0;
      chk(clr == 3'b000, "R8 busy write ignored", int'(clr), 0);
      chk(bits == 3'b001, "R8 busy write leaves bits", int'(bits), 1);

      // R9: hardware reset during software reset
      wait_idle();
      strap = 8'h5A;
      @(negedge clk); wr = 1'b1; addr = 16'h001F; data = 16'h8000;
      @(negedge clk); wr = 1'b0;
      chk(bits == 3'b010, "R9 software reset started", int'(bits), 2);
      @(negedge clk); pin = 1'b0;
      repeat (LOWC + 3) @(negedge clk);
      chk(bits == 3'b000, "R9 control bit aborted", int'(bits), 0);
      chk(busy == 1'b1, "R9 busy kept", int'(busy), 1);
      repeat (3) @(negedge clk);
      pin = 1'b1;
      seen = 3'b000;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         if (clr != 3'b000) begin seen = clr; break; end
      end
      chk(seen == 3'b111, "R9 hardware sequence follows", int'(seen), 7);
      chk(cfg == 8'h5A, "R9 straps relatched", int'(cfg), 8'h5A);
      count_busy(nb, nbt);
      chk(nb == HOLDC, "R9 busy after release", nb, HOLDC);

      // Constrained random mix
      for (int it = 0; it < 60; it++) begin
         int unsigned r;
         logic [DW-1:0] d;
         r = $urandom % 8;
         d = DW'($urandom);
         case (r)
            0: sw_case(16'h0000, d | 16'h8000);
            1: sw_case(16'h001F, d | 16'h8000);
            2: sw_case(16'h0D01, d | 16'h4000);
            3: sw_case(AW'($urandom % 64), d);
            4: sw_case(16'h0D01, d);
            5: hw_case(1 + int'($urandom % (LOWC - 1)), CW'($urandom));
            6: sw_case(16'h0000, d);
            default: begin
               if ($urandom % 3 == 0) hw_case(LOWC + int'($urandom % 8), CW'($urandom));
               else sw_case(16'h001F, d);
            end
         endcase
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule